// File: doc/BRIEF.md
# Power Domain On/Off Sequencer

This block is a hardware state machine that switches a single gated power domain on and off in a fixed, safe order. It drives one control word that covers the domain's reset, isolation, a two-stage power switch, a clock gate and a field of SRAM power-down lines. It also drives a request line to the interconnect's bus-protection logic. It waits on acknowledges from the power switches, from the SRAM macros and from the protection logic. Every wait has its own timeout counted in clock cycles.

Software asks for a change with a one-cycle `req_on` or `req_off` pulse. The block answers with a one-cycle `done` pulse when the sequence completes. It reports `busy` while a sequence runs and `is_on` once the domain has settled on. A wait that runs out raises a sticky `err`, and the outputs then stay exactly where the sequence stopped. The next accepted request clears `err` and starts its sequence from those held outputs. After a synchronous reset the block powers the domain up without being asked.

Top module: `pwr_seq`

## Requirements
- R1: During reset, `ctl_word` holds the off pattern 0x0F12. In that pattern bit 0 (active-low reset) is 0, bit 1 (isolation) is 1, bit 2 (primary switch) is 0, bit 3 (secondary switch) is 0, bit 4 (clock disable) is 1, bits 11:8 (SRAM power-down) are all 1, and bits 7:5 are 0. Also during reset, `prot_req` is 1 when protection is enabled, `busy` is 1, and `done`, `err` and `is_on` are 0.
- R2: Once reset is released, a power-up sequence runs with no request. It ends with a `done` pulse and `is_on` set to 1.
- R3: Power-up changes the outputs in this order: set bit 2, set bit 3, wait until both power acknowledges are high, clear bit 4, clear bit 1, set bit 0, clear bits 11:8, wait until every SRAM acknowledge selected by `ACK_MASK` is 0, and then drop `prot_req`.
- R4: At most one control step changes per clock cycle. A step is one of bits 0 to 4, the whole SRAM field taken together, or `prot_req`.
- R5: Power-down changes the outputs in this order: raise `prot_req` and wait for `prot_grant`, set bits 11:8 and wait until every masked SRAM acknowledge is 1, then set bit 1, clear bit 0, set bit 4, clear bit 2, clear bit 3, and wait until both power acknowledges are low.
- R6: The SRAM field is raised only after `prot_grant` was seen. `prot_req` is released only as the last step of power-up, in the same cycle that `done` appears.
- R7: If a wait condition is not met within `TIMEOUT` cycles, the sequence aborts. `err` goes to 1, `busy` goes to 0, no `done` is given, and `ctl_word` and `prot_req` hold their last values.
- R8: An accepted request clears `err` in the cycle after it is sampled. After an abort, an on request restarts power-up from the held outputs, and only the steps that still change an output show up at the outputs.
- R9: An on or off request that arrives while `busy` is 1 has no effect.
- R10: A request for the state the domain has already settled in gives `done` in the next cycle, keeps `busy` at 0 and changes no output.
- R11: When `ACK_MASK` is 0, both SRAM acknowledge waits are skipped. When `PROT_EN` is 0, the protection steps are skipped and `prot_req` stays 0.
- R12: While exactly one of the two power acknowledges is high, the sequence keeps waiting and makes no further output change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_on | input | 1 | One-cycle power-on request |
| req_off | input | 1 | One-cycle power-off request |
| sw_ack_pri | input | 1 | Primary power switch acknowledge |
| sw_ack_sec | input | 1 | Secondary power switch acknowledge |
| sram_ack | input | ACK_W | SRAM power-down acknowledges, qualified by `ACK_MASK` |
| prot_grant | input | 1 | Bus protection granted |
| ctl_word | output | PDN_W+8 | Domain control word (layout in R1) |
| prot_req | output | 1 | Bus protection request |
| busy | output | 1 | A sequence is running |
| is_on | output | 1 | Domain has settled on |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky timeout error |

## Verification
The assertions check on every cycle that only one control step changes per cycle. They also check the causal links in the order: clock enable only after both switch acknowledges, isolation only after the SRAM acknowledges are full, SRAM power-down only after the grant, and protection released only at completion. They further check that an error rises only out of a wait, and that a request for the current state completes at once. Only the bench scenarios can show the complete order of steps against an independent model of the outputs, and what happens when the two acknowledges disagree for a long time. The same holds for aborts at each kind of wait, the recovery from held outputs, ignored requests, and the build variant that skips the SRAM and protection steps.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    // Bit positions inside the control word
    localparam int B_RSTN   = 0;
    localparam int B_ISO    = 1;
    localparam int B_ON_PRI = 2;
    localparam int B_ON_SEC = 3;
    localparam int B_CKDIS  = 4;
    localparam int PDN_LSB  = 8;
    localparam int GATE_W   = 5;
    localparam int PAD_W    = PDN_LSB - GATE_W;

    // Single-bit gate controls, packed so that rstn lands on bit 0
    typedef struct packed {
        logic ckdis;
        logic on_sec;
        logic on_pri;
        logic iso;
        logic rstn;
    } gate_bits_t;

    localparam gate_bits_t GATE_OFF = '{ckdis: 1'b1, on_sec: 1'b0,
                                        on_pri: 1'b0, iso: 1'b1, rstn: 1'b0};

    typedef enum logic [4:0] {
        S_IDLE,
        U_ON_PRI, U_ON_SEC, U_WPWR, U_CLK, U_ISO, U_RST, U_SRAM, U_WSRAM, U_PROT,
        D_PROT, D_WPROT, D_SRAM, D_WSRAM, D_ISO, D_RST, D_CLK, D_ON_PRI, D_ON_SEC, D_WPWR
    } seq_state_t;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_PRI_SET, CMD_SEC_SET, CMD_CK_CLR, CMD_ISO_CLR, CMD_RST_REL, CMD_PDN_CLR,
        CMD_PROT_REL, CMD_PROT_SET, CMD_PDN_SET, CMD_ISO_SET, CMD_RST_ASRT,
        CMD_CK_SET, CMD_PRI_CLR, CMD_SEC_CLR
    } step_cmd_t;

    typedef enum logic [1:0] {
        DOM_OFF,
        DOM_ON,
        DOM_UNK
    } dom_state_t;

    function automatic logic is_wait(input seq_state_t s);
        return (s == U_WPWR) || (s == U_WSRAM) || (s == D_WPROT) ||
               (s == D_WSRAM) || (s == D_WPWR);
    endfunction

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer
    import pwr_seq_pkg::*;
#(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT + 1);

    logic [CW-1:0] cnt_q;

    // Counts cycles spent in the current wait; cleared whenever no wait is active
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == CW'(TIMEOUT - 1));

endmodule

// File: rtl/pwr_seq_ctl.sv
module pwr_seq_ctl
    import pwr_seq_pkg::*;
#(
    parameter int PDN_W   = 4,
    parameter bit PROT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  step_cmd_t         cmd,
    output logic [PDN_W+7:0]  ctl_word,
    output logic              prot_req
);
    gate_bits_t        gate_q;
    logic [PDN_W-1:0]  pdn_q;
    logic              prot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= GATE_OFF;
            pdn_q  <= '1;
            prot_q <= PROT_EN;
        end else begin
            unique case (cmd)
                CMD_PRI_SET:  gate_q.on_pri <= 1'b1;
                CMD_SEC_SET:  gate_q.on_sec <= 1'b1;
                CMD_CK_CLR:   gate_q.ckdis  <= 1'b0;
                CMD_ISO_CLR:  gate_q.iso    <= 1'b0;
                CMD_RST_REL:  gate_q.rstn   <= 1'b1;
                CMD_PDN_CLR:  pdn_q         <= '0;
                CMD_PROT_REL: prot_q        <= 1'b0;
                CMD_PROT_SET: prot_q        <= PROT_EN;
                CMD_PDN_SET:  pdn_q         <= '1;
                CMD_ISO_SET:  gate_q.iso    <= 1'b1;
                CMD_RST_ASRT: gate_q.rstn   <= 1'b0;
                CMD_CK_SET:   gate_q.ckdis  <= 1'b1;
                CMD_PRI_CLR:  gate_q.on_pri <= 1'b0;
                CMD_SEC_CLR:  gate_q.on_sec <= 1'b0;
                default: ;
            endcase
        end
    end

    assign ctl_word = {pdn_q, {PAD_W{1'b0}}, gate_q};
    assign prot_req = prot_q;

    logic pv_q;
    always_ff @(posedge clk) begin
        if (rst) pv_q <= 1'b0;
        else     pv_q <= 1'b1;
    end

    // R4: one step per cycle (each gate bit, the SRAM field as a group, protection)
    p_one_step_r4: assert property (@(posedge clk) disable iff (rst || !pv_q)
        $onehot0({gate_q ^ $past(gate_q), |(pdn_q ^ $past(pdn_q)), prot_q ^ $past(prot_q)}));

    // R11: the SRAM field always moves as a whole
    p_pdn_whole_r11: assert property (@(posedge clk) disable iff (rst)
        (pdn_q == '0) || (pdn_q == '1));

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int             ACK_W    = 4,
    parameter logic [ACK_W-1:0] ACK_MASK = '1,
    parameter bit             PROT_EN  = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_on,
    input  logic             req_off,
    input  logic             sw_ack_pri,
    input  logic             sw_ack_sec,
    input  logic [ACK_W-1:0] sram_ack,
    input  logic             prot_grant,
    input  logic             expired,
    output step_cmd_t        cmd,
    output logic             wait_active,
    output logic             busy,
    output logic             is_on,
    output logic             done,
    output logic             err
);
    localparam bit HAS_ACK = (ACK_MASK != '0);

    seq_state_t state_q, nxt;
    dom_state_t dom_q;
    logic       done_q, err_q;
    logic       fin, fin_on, abort, launch, accept;

    logic             pwr_hi, pwr_lo, sram_clear, sram_full;
    logic [ACK_W-1:0] sram_m;

    assign pwr_hi     = sw_ack_pri && sw_ack_sec;
    assign pwr_lo     = !sw_ack_pri && !sw_ack_sec;
    assign sram_m     = sram_ack & ACK_MASK;
    assign sram_clear = (sram_m == '0);
    assign sram_full  = (sram_m == ACK_MASK);
    assign accept     = (state_q == S_IDLE) && (req_on || req_off);

    always_comb begin
        nxt    = state_q;
        cmd    = CMD_NONE;
        fin    = 1'b0;
        fin_on = 1'b0;
        abort  = 1'b0;
        launch = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_on) begin
                    if (dom_q == DOM_ON) begin
                        fin    = 1'b1;
                        fin_on = 1'b1;
                    end else begin
                        nxt    = U_ON_PRI;
                        launch = 1'b1;
                    end
                end else if (req_off) begin
                    if (dom_q == DOM_OFF) begin
                        fin = 1'b1;
                    end else begin
                        nxt    = PROT_EN ? D_PROT : D_SRAM;
                        launch = 1'b1;
                    end
                end
            end
            // ---------------- power-up ----------------
            U_ON_PRI: begin cmd = CMD_PRI_SET; nxt = U_ON_SEC; end
            U_ON_SEC: begin cmd = CMD_SEC_SET; nxt = U_WPWR;   end
            U_WPWR: begin
                if (pwr_hi)       nxt = U_CLK;
                else if (expired) abort = 1'b1;
            end
            U_CLK: begin cmd = CMD_CK_CLR;  nxt = U_ISO;  end
            U_ISO: begin cmd = CMD_ISO_CLR; nxt = U_RST;  end
            U_RST: begin cmd = CMD_RST_REL; nxt = U_SRAM; end
            U_SRAM: begin
                cmd = CMD_PDN_CLR;
                if (HAS_ACK)      nxt = U_WSRAM;
                else if (PROT_EN) nxt = U_PROT;
                else begin
                    fin    = 1'b1;
                    fin_on = 1'b1;
                end
            end
            U_WSRAM: begin
                if (sram_clear) begin
                    if (PROT_EN) nxt = U_PROT;
                    else begin
                        fin    = 1'b1;
                        fin_on = 1'b1;
                    end
                end else if (expired) begin
                    abort = 1'b1;
                end
            end
            U_PROT: begin
                cmd    = CMD_PROT_REL;
                fin    = 1'b1;
                fin_on = 1'b1;
            end
            // ---------------- power-down ----------------
            D_PROT: begin cmd = CMD_PROT_SET; nxt = D_WPROT; end
            D_WPROT: begin
                if (prot_grant)   nxt = D_SRAM;
                else if (expired) abort = 1'b1;
            end
            D_SRAM: begin
                cmd = CMD_PDN_SET;
                nxt = HAS_ACK ? D_WSRAM : D_ISO;
            end
            D_WSRAM: begin
                if (sram_full)    nxt = D_ISO;
                else if (expired) abort = 1'b1;
            end
            D_ISO:    begin cmd = CMD_ISO_SET;  nxt = D_RST;    end
            D_RST:    begin cmd = CMD_RST_ASRT; nxt = D_CLK;    end
            D_CLK:    begin cmd = CMD_CK_SET;   nxt = D_ON_PRI; end
            D_ON_PRI: begin cmd = CMD_PRI_CLR;  nxt = D_ON_SEC; end
            D_ON_SEC: begin cmd = CMD_SEC_CLR;  nxt = D_WPWR;   end
            D_WPWR: begin
                if (pwr_lo)       fin = 1'b1;
                else if (expired) abort = 1'b1;
            end
            default: nxt = S_IDLE;
        endcase
        if (fin || abort) nxt = S_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= U_ON_PRI;
            dom_q   <= DOM_UNK;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= nxt;
            done_q  <= fin;
            if (fin)                  dom_q <= fin_on ? DOM_ON : DOM_OFF;
            else if (launch || abort) dom_q <= DOM_UNK;
            if (abort)       err_q <= 1'b1;
            else if (accept) err_q <= 1'b0;
        end
    end

    assign wait_active = is_wait(state_q);
    assign busy        = (state_q != S_IDLE);
    assign is_on       = (dom_q == DOM_ON);
    assign done        = done_q;
    assign err         = err_q;

    logic pv_q;
    always_ff @(posedge clk) begin
        if (rst) pv_q <= 1'b0;
        else     pv_q <= 1'b1;
    end

    // R7: an error only ever rises out of a wait step
    p_err_from_wait_r7: assert property (@(posedge clk) disable iff (rst || !pv_q)
        $rose(err_q) |-> $past(wait_active));

    // R7: an aborted sequence leaves the block idle
    p_abort_idle_r7: assert property (@(posedge clk) disable iff (rst || !pv_q)
        $rose(err_q) |-> !busy && !done_q);

    // R8: a completion never carries a stale error
    p_done_clean_r8: assert property (@(posedge clk) disable iff (rst)
        !(done_q && err_q));

endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
    import pwr_seq_pkg::*;
#(
    parameter int               PDN_W    = 4,
    parameter int               ACK_W    = 4,
    parameter logic [ACK_W-1:0] ACK_MASK = '1,
    parameter bit               PROT_EN  = 1'b1,
    parameter int               TIMEOUT  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_on,
    input  logic              req_off,
    input  logic              sw_ack_pri,
    input  logic              sw_ack_sec,
    input  logic [ACK_W-1:0]  sram_ack,
    input  logic              prot_grant,
    output logic [PDN_W+7:0]  ctl_word,
    output logic              prot_req,
    output logic              busy,
    output logic              is_on,
    output logic              done,
    output logic              err
);
    step_cmd_t cmd;
    logic      wait_active;
    logic      expired;

    pwr_seq_fsm #(
        .ACK_W    (ACK_W),
        .ACK_MASK (ACK_MASK),
        .PROT_EN  (PROT_EN)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_on      (req_on),
        .req_off     (req_off),
        .sw_ack_pri  (sw_ack_pri),
        .sw_ack_sec  (sw_ack_sec),
        .sram_ack    (sram_ack),
        .prot_grant  (prot_grant),
        .expired     (expired),
        .cmd         (cmd),
        .wait_active (wait_active),
        .busy        (busy),
        .is_on       (is_on),
        .done        (done),
        .err         (err)
    );

    pwr_seq_timer #(
        .TIMEOUT (TIMEOUT)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (wait_active),
        .expired (expired)
    );

    pwr_seq_ctl #(
        .PDN_W   (PDN_W),
        .PROT_EN (PROT_EN)
    ) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .ctl_word (ctl_word),
        .prot_req (prot_req)
    );

    // Cycles since reset, saturating, for properties that look two cycles back
    logic [1:0] pv_cnt;
    always_ff @(posedge clk) begin
        if (rst)                pv_cnt <= '0;
        else if (pv_cnt != 2'd3) pv_cnt <= pv_cnt + 1'b1;
    end

    // R3, R12: clock enabled only after both switch acknowledges were high
    p_clk_after_acks_r3: assert property (@(posedge clk) disable iff (rst || pv_cnt != 2'd3)
        $fell(ctl_word[B_CKDIS]) |-> $past(sw_ack_pri && sw_ack_sec, 2));

    // R5: isolation applied only after all masked SRAM acknowledges were set
    p_iso_after_sram_r5: assert property (@(posedge clk) disable iff (rst || pv_cnt != 2'd3)
        $rose(ctl_word[B_ISO]) |-> ($past(sram_ack & ACK_MASK, 2) == ACK_MASK));

    // R10: a request for the settled state completes at once without output change
    p_same_state_r10: assert property (@(posedge clk) disable iff (rst || pv_cnt == 2'd0)
        (!busy && req_on && is_on) |=> done && !busy && $stable(ctl_word) && $stable(prot_req));

    generate
        if (PROT_EN) begin : g_prot
            // R6: SRAM power-down only once protection had been granted
            p_sram_after_grant_r6: assert property (@(posedge clk) disable iff (rst || pv_cnt != 2'd3)
                $rose(|ctl_word[PDN_LSB +: PDN_W]) |-> $past(prot_grant, 2));
            // R6: protection released only as the final power-up step
            p_prot_release_last_r6: assert property (@(posedge clk) disable iff (rst || pv_cnt == 2'd0)
                $fell(prot_req) |-> done && !busy && (ctl_word[PDN_LSB +: PDN_W] == '0));
        end else begin : g_noprot
            // R11: protection never requested when disabled
            p_no_prot_r11: assert property (@(posedge clk) disable iff (rst)
                !prot_req);
        end
    endgenerate

endmodule

// File: tb/pwr_seq_test.sv
module pwr_seq_test;
    localparam int TO = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int errors = 0;

    // ---------------- main instance ----------------
    logic        req_on = 1'b0, req_off = 1'b0;
    logic        ack_pri = 1'b0, ack_sec = 1'b0;
    logic [3:0]  sram_ack = 4'hF;
    logic        grant = 1'b1;
    logic [11:0] ctl;
    logic        prot, busy, is_on, done, err;

    pwr_seq #(.TIMEOUT(TO)) uut (
        .clk(clk), .rst(rst), .req_on(req_on), .req_off(req_off),
        .sw_ack_pri(ack_pri), .sw_ack_sec(ack_sec), .sram_ack(sram_ack),
        .prot_grant(grant), .ctl_word(ctl), .prot_req(prot),
        .busy(busy), .is_on(is_on), .done(done), .err(err)
    );

    // ---------------- variant: no SRAM acks, no protection ----------------
    logic        reqb_off = 1'b0;
    logic        ackb_pri = 1'b0, ackb_sec = 1'b0;
    logic [11:0] ctl_b;
    logic        prot_b, busy_b, is_on_b, done_b, err_b;
    int          done_b_cnt = 0;
    bit          prot_b_seen = 1'b0;

    pwr_seq #(.ACK_MASK(4'h0), .PROT_EN(1'b0), .TIMEOUT(TO)) uut_b (
        .clk(clk), .rst(rst), .req_on(1'b0), .req_off(reqb_off),
        .sw_ack_pri(ackb_pri), .sw_ack_sec(ackb_sec), .sram_ack(4'hA),
        .prot_grant(1'b0), .ctl_word(ctl_b), .prot_req(prot_b),
        .busy(busy_b), .is_on(is_on_b), .done(done_b), .err(err_b)
    );

    // ---------------- environment models ----------------
    int  lat_pri = 3, lat_sec = 2, lat_sram = 2, lat_grant = 1;
    int  c_pri = 0, c_sec = 0, c_sram = 0, c_grant = 0;
    bit  stuck_sec = 1'b0, stuck_sram = 1'b0, stuck_grant = 1'b0;

    always @(posedge clk) begin
        if (ack_pri != ctl[2]) begin
            if (c_pri >= lat_pri) begin ack_pri <= ctl[2]; c_pri <= 0; end
            else c_pri <= c_pri + 1;
        end else c_pri <= 0;
        if (ack_sec != (ctl[3] && !stuck_sec)) begin
            if (c_sec >= lat_sec) begin ack_sec <= ctl[3] && !stuck_sec; c_sec <= 0; end
            else c_sec <= c_sec + 1;
        end else c_sec <= 0;
        if (!stuck_sram && sram_ack != ctl[11:8]) begin
            if (c_sram >= lat_sram) begin sram_ack <= ctl[11:8]; c_sram <= 0; end
            else c_sram <= c_sram + 1;
        end else c_sram <= 0;
        if (grant != (prot && !stuck_grant)) begin
            if (c_grant >= lat_grant) begin grant <= prot && !stuck_grant; c_grant <= 0; end
            else c_grant <= c_grant + 1;
        end else c_grant <= 0;
        ackb_pri <= ctl_b[2];
        ackb_sec <= ctl_b[3];
        if (done_b) done_b_cnt <= done_b_cnt + 1;
        if (prot_b) prot_b_seen <= 1'b1;
    end

    // ---------------- reference model of observable steps ----------------
    logic [12:0] mw;          // expected {prot_req, ctl_word}
    logic [12:0] expq[$];
    logic [12:0] prev_obs;
    bit          mon_init = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [12:0] nw);
        if (nw != mw) begin
            expq.push_back(nw);
            mw = nw;
        end
    endtask

    // Power-up steps, segments cut at each wait so an abort can be modelled
    task automatic exp_up(input int nseg);
        if (nseg >= 1) begin
            step(mw | 13'h0004);
            step(mw | 13'h0008);
        end
        if (nseg >= 2) begin
            step(mw & ~13'h0010);
            step(mw & ~13'h0002);
            step(mw | 13'h0001);
            step(mw & ~13'h0F00);
        end
        if (nseg >= 3) step(mw & ~13'h1000);
    endtask

    task automatic exp_down(input int nseg);
        if (nseg >= 1) step(mw | 13'h1000);
        if (nseg >= 2) step(mw | 13'h0F00);
        if (nseg >= 3) begin
            step(mw | 13'h0002);
            step(mw & ~13'h0001);
            step(mw | 13'h0010);
            step(mw & ~13'h0004);
            step(mw & ~13'h0008);
        end
    endtask

    // Every clock: any output change must be the next expected step (R3, R4, R5)
    always @(negedge clk) begin
        logic [12:0] obs;
        obs = {prot, ctl};
        if (!mon_init) begin
            mon_init = 1'b1;
        end else if (obs != prev_obs) begin
            if (expq.size() == 0) begin
                check(1'b0, "R3/R5 unexpected output change", obs, prev_obs);
            end else begin
                logic [12:0] e;
                e = expq.pop_front();
                check(obs == e, "R3/R5 step order", obs, e);
            end
            check($countones(obs ^ prev_obs) == 1 || (obs ^ prev_obs) == 13'h0F00,
                  "R4 single step", obs ^ prev_obs, 0);
        end
        prev_obs = obs;
    end

    task automatic pulse_on();
        req_on = 1'b1;
        @(negedge clk);
        req_on = 1'b0;
    endtask

    task automatic pulse_off();
        req_off = 1'b1;
        @(negedge clk);
        req_off = 1'b0;
    endtask

    task automatic wait_end(output int cyc);
        cyc = 0;
        while (!done && !err && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        int cyc;
        mw = 13'h1F12;
        repeat (4) @(negedge clk);
        // R1 reset state
        check({prot, ctl} == 13'h1F12, "R1 reset word", {prot, ctl}, 13'h1F12);
        check(busy == 1'b1, "R1 busy in reset", busy, 1);
        check(!done && !err && !is_on, "R1 flags in reset", {done, err, is_on}, 0);

        // R2 automatic power-up
        exp_up(3);
        rst = 1'b0;
        wait_end(cyc);
        check(done && !err, "R2 auto power-up done", {done, err}, 2'b10);
        @(negedge clk);
        check(is_on && !busy, "R2 settled on", {is_on, busy}, 2'b10);
        check(expq.size() == 0, "R3 all up steps seen", expq.size(), 0);
        check(done_b_cnt == 1 && is_on_b, "R11 variant auto power-up", {done_b_cnt[3:0], is_on_b}, 5'h3);

        // R10 on request while already on
        pulse_on();
        check(done && !busy, "R10 immediate done", {done, busy}, 2'b10);
        repeat (5) @(negedge clk);
        check({prot, ctl} == 13'h000D, "R10 no output change", {prot, ctl}, 13'h000D);

        // R5 power-down, with an on request while busy (R9)
        exp_down(3);
        pulse_off();
        repeat (3) @(negedge clk);
        pulse_on();
        wait_end(cyc);
        check(done && !err, "R5 power-down done", {done, err}, 2'b10);
        @(negedge clk);
        check(!is_on && expq.size() == 0, "R5 all down steps seen", expq.size(), 0);
        repeat (15) @(negedge clk);
        check(!busy && {prot, ctl} == 13'h1F12, "R9 busy request ignored", {busy, prot, ctl}, 13'h1F12);

        // R10 off request while off
        pulse_off();
        check(done && !busy, "R10 immediate done when off", {done, busy}, 2'b10);

        // R12 mismatched acknowledges keep the wait going
        lat_sec = 20;
        exp_up(3);
        pulse_on();
        cyc = 0;
        while (!(ack_pri && !ack_sec) && cyc < 100) begin @(negedge clk); cyc++; end
        repeat (3) @(negedge clk);
        check(ack_pri && !ack_sec && busy && {prot, ctl} == 13'h1F1E,
              "R12 hold while acks disagree", {prot, ctl}, 13'h1F1E);
        wait_end(cyc);
        check(done && !err, "R12 completes after agreement", {done, err}, 2'b10);
        lat_sec = 2;
        @(negedge clk);

        // R7 timeout at the SRAM acknowledge wait during power-down
        stuck_sram = 1'b1;
        exp_down(2);
        pulse_off();
        wait_end(cyc);
        check(err && !done && !busy, "R7 SRAM wait abort", {err, done, busy}, 3'b100);
        check(cyc >= TO, "R7 abort not before timeout", cyc, TO);
        repeat (5) @(negedge clk);
        check({prot, ctl} == 13'h1F0D && err, "R7 outputs held", {prot, ctl}, 13'h1F0D);

        // R8 recovery from held outputs
        stuck_sram = 1'b0;
        repeat (6) @(negedge clk);
        exp_up(3);
        pulse_on();
        check(!err, "R8 request clears error", err, 0);
        wait_end(cyc);
        check(done && !err, "R8 recovery power-up done", {done, err}, 2'b10);
        @(negedge clk);
        check(is_on && expq.size() == 0, "R8 recovery steps", expq.size(), 0);

        // R6/R7 protection grant never arrives
        stuck_grant = 1'b1;
        exp_down(1);
        pulse_off();
        wait_end(cyc);
        check(err && {prot, ctl} == 13'h100D, "R6 no SRAM power-down without grant", {prot, ctl}, 13'h100D);
        stuck_grant = 1'b0;
        exp_up(3);
        pulse_on();
        wait_end(cyc);
        check(done && {prot, ctl} == 13'h000D, "R6 protection released last", {prot, ctl}, 13'h000D);
        @(negedge clk);

        // R7 secondary switch never acknowledges during power-up
        exp_down(3);
        pulse_off();
        wait_end(cyc);
        check(done, "R5 second power-down", done, 1);
        stuck_sec = 1'b1;
        exp_up(1);
        pulse_on();
        wait_end(cyc);
        check(err && !done && {prot, ctl} == 13'h1F1E, "R7 power ack abort", {prot, ctl}, 13'h1F1E);
        stuck_sec = 1'b0;
        repeat (6) @(negedge clk);
        exp_up(3);
        pulse_on();
        wait_end(cyc);
        check(done && !err, "R8 recovery after power abort", {done, err}, 2'b10);
        @(negedge clk);
        check(is_on && expq.size() == 0, "R8 recovery steps after power abort", expq.size(), 0);

        // R11 variant power-down skips SRAM and protection steps
        reqb_off = 1'b1;
        @(negedge clk);
        reqb_off = 1'b0;
        cyc = 0;
        while (done_b_cnt < 2 && cyc < 200) begin @(negedge clk); cyc++; end
        @(negedge clk);
        check(done_b_cnt == 2 && !is_on_b && !err_b && ctl_b == 12'hF12,
              "R11 variant power-down", ctl_b, 12'hF12);
        check(!prot_b_seen, "R11 no protection request", prot_b_seen, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule